// File: doc/BRIEF.md
# Directed Rounding and Overflow Selector

This combinational unit finishes a floating-point result. It takes a mantissa with two extra low-order bits below the retained precision and a separate sticky flag that holds the OR of all bits lost earlier. It removes the two extra bits and decides, under one of four rounding modes, whether to increment the retained part. It returns the rounded mantissa and a rounded-up indication, together with inexact, fraction-inexact and fraction-rounded flags.

The increment carries through every bit. A mantissa of all ones therefore becomes a power of two, which shows up in the extra top bit of the output. Renormalising that value and adjusting the exponent is left to the caller.

A second path handles overflow. For the given sign and mode, it tells the caller whether an overflowing result should become infinity or the largest finite magnitude. It raises an overflow flag whenever infinity is chosen.

Top module: `dir_round_ovf`

## Requirements
- R1: The rounded mantissa is the input shifted right by two, plus one when rounding up. It is one bit wider than the retained field, and its top bit catches the carry. Bit 1 of the input is the guard bit and bit 0 is the round bit.
- R2: When guard, round and sticky are all 0, the result is exact: no flag is raised and `rnd_up_o` is 0.
- R3: When any of guard, round or sticky is 1, both `inexact_o` and `frac_inexact_o` are 1.
- R4: Mode 0 (nearest) rounds up only when guard is 1 and at least one of round, sticky, or bit 0 of the shifted mantissa is 1. An exact halfway case therefore goes to even.
- R5: Mode 1 (toward zero) never rounds up.
- R6: Mode 2 (toward plus infinity) rounds up on an inexact result only when `sign_i` is 0.
- R7: Mode 3 (toward minus infinity) rounds up on an inexact result only when `sign_i` is 1.
- R8: A round-up sets `rnd_up_o` and `frac_rounded_o` and propagates the carry fully. An all-ones retained field yields only the top output bit set.
- R9: `ovf_to_inf_o` behaves as follows per mode:
  - mode 0: always 1
  - mode 1: always 0
  - mode 2: equal to NOT `sign_i`
  - mode 3: equal to `sign_i`
- R10: `ovf_flag_o` is 1 exactly when `ovf_to_inf_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_i | input | MANT_W (26) | mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of bits discarded earlier |
| sign_i | input | 1 | 1 for a negative value |
| mode_i | input | 2 | rounding mode: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | MANT_W-1 (25) | rounded mantissa; top bit holds the carry |
| rnd_up_o | output | 1 | 1 when the value was incremented |
| inexact_o | output | 1 | result is not exact |
| frac_inexact_o | output | 1 | fraction-inexact flag |
| frac_rounded_o | output | 1 | fraction was rounded up |
| ovf_to_inf_o | output | 1 | 1: overflow goes to infinity; 0: overflow goes to largest finite |
| ovf_flag_o | output | 1 | overflow flag, raised when infinity is chosen |

## Verification
The embedded assertions check several rules on every input change:
- an exact input leaves every flag clear and the output equal to the shifted input;
- a round-up adds exactly one;
- toward-zero never increments;
- the overflow flag follows the infinity decision.

Only the bench scenarios can show the mode-by-mode rounding choices against independently derived values. These include the halfway-to-even cases, the sign dependence of the directed modes, and the carry running out of an all-ones field.

// File: rtl/round_sel_pkg.sv
package round_sel_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_POS_INF = 2'd2,
        RM_NEG_INF = 2'd3
    } rmode_e;

    typedef struct packed {
        logic guard;
        logic rnd;
        logic sticky;
        logic lsb;
    } tail_t;

    function automatic logic tail_lost(input tail_t t);
        return t.guard | t.rnd | t.sticky;
    endfunction

endpackage

// File: rtl/round_decide.sv
module round_decide
    import round_sel_pkg::*;
(
    input  logic   [1:0] mode_i,
    input  logic         sign_i,
    input  tail_t        tail_i,
    output logic         inexact_o,
    output logic         up_o
);
    rmode_e mode;
    logic   want;

    assign mode = rmode_e'(mode_i);

    always_comb begin
        inexact_o = tail_lost(tail_i);
        unique case (mode)
            RM_ZERO:    want = 1'b0;
            RM_POS_INF: want = ~sign_i;
            RM_NEG_INF: want = sign_i;
            default:    want = tail_i.guard & (tail_i.rnd | tail_i.sticky | tail_i.lsb);
        endcase
        up_o = inexact_o & want;
    end

    always_comb begin
        if (!$isunknown({mode_i, tail_i})) begin
            a_r5_zero_no_up: assert (!(mode == RM_ZERO && up_o));
        end
    end
endmodule

// File: rtl/round_bump.sv
module round_bump #(
    parameter int W = 24
) (
    input  logic [W-1:0] val_i,
    input  logic         inc_i,
    output logic [W:0]   sum_o
);
    logic [W:0] carry;

    assign carry[0] = inc_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]   = val_i[i] ^ carry[i];
        assign carry[i+1] = val_i[i] & carry[i];
    end

    assign sum_o[W] = carry[W];

    always_comb begin
        if (!$isunknown({val_i, inc_i})) begin
            a_r8_plus_one: assert (sum_o == ({1'b0, val_i} + {{W{1'b0}}, inc_i}));
        end
    end
endmodule

// File: rtl/ovf_select.sv
module ovf_select
    import round_sel_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    output logic       to_inf_o
);
    always_comb begin
        unique case (rmode_e'(mode_i))
            RM_ZERO:    to_inf_o = 1'b0;
            RM_POS_INF: to_inf_o = ~sign_i;
            RM_NEG_INF: to_inf_o = sign_i;
            default:    to_inf_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dir_round_ovf.sv
module dir_round_ovf
    import round_sel_pkg::*;
#(
    parameter int MANT_W = 26,
    localparam int KEEP_W = MANT_W - 2
) (
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic              sign_i,
    input  logic [1:0]        mode_i,
    output logic [KEEP_W:0]   mant_o,
    output logic              rnd_up_o,
    output logic              inexact_o,
    output logic              frac_inexact_o,
    output logic              frac_rounded_o,
    output logic              ovf_to_inf_o,
    output logic              ovf_flag_o
);
    logic [KEEP_W-1:0] kept;
    tail_t             tail;
    logic              lost;
    logic              up;
    logic              to_inf;

    assign kept = mant_i[MANT_W-1:2];

    always_comb begin
        tail.guard  = mant_i[1];
        tail.rnd    = mant_i[0];
        tail.sticky = sticky_i;
        tail.lsb    = kept[0];
    end

    round_decide u_decide (
        .mode_i   (mode_i),
        .sign_i   (sign_i),
        .tail_i   (tail),
        .inexact_o(lost),
        .up_o     (up)
    );

    round_bump #(.W(KEEP_W)) u_bump (
        .val_i(kept),
        .inc_i(up),
        .sum_o(mant_o)
    );

    ovf_select u_ovf (
        .mode_i  (mode_i),
        .sign_i  (sign_i),
        .to_inf_o(to_inf)
    );

    assign rnd_up_o       = up;
    assign frac_rounded_o = up;
    assign inexact_o      = lost;
    assign frac_inexact_o = lost;
    assign ovf_to_inf_o   = to_inf;
    assign ovf_flag_o     = to_inf;

    always_comb begin
        if (!$isunknown({mant_i, sticky_i, sign_i, mode_i})) begin
            if (mant_i[1:0] == 2'b00 && !sticky_i) begin
                a_r2_exact_clean: assert (!inexact_o && !frac_inexact_o && !rnd_up_o
                                          && !frac_rounded_o && mant_o == {1'b0, kept});
            end
            if (mode_i == 2'd1) begin
                a_r9_zero_finite: assert (!ovf_to_inf_o);
            end
            a_r10_flag_follows: assert (ovf_flag_o == ovf_to_inf_o);
            a_r3_flags_pair: assert (inexact_o == frac_inexact_o);
        end
    end
endmodule

// File: tb/sim_dir_round_ovf.sv
module sim_dir_round_ovf;
    localparam int MW = 26;
    localparam int OW = MW - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [MW-1:0] mant;
    logic          sticky, sign;
    logic [1:0]    mode;
    logic [OW-1:0] mant_o;
    logic          up_o, inx_o, fi_o, fr_o, inf_o, ovf_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    dir_round_ovf #(.MANT_W(MW)) u0 (
        .mant_i(mant), .sticky_i(sticky), .sign_i(sign), .mode_i(mode),
        .mant_o(mant_o), .rnd_up_o(up_o), .inexact_o(inx_o),
        .frac_inexact_o(fi_o), .frac_rounded_o(fr_o),
        .ovf_to_inf_o(inf_o), .ovf_flag_o(ovf_o)
    );

    // mode(2) sign(1) sticky(1) mant(26) exp_mant(25) exp_up exp_inexact exp_inf
    localparam logic [57:0] VECS [16] = '{
        {2'd0, 1'b0, 1'b0, 26'h0000010, 25'h0000004, 1'b0, 1'b0, 1'b1},
        {2'd0, 1'b0, 1'b0, 26'h0000012, 25'h0000004, 1'b0, 1'b1, 1'b1},
        {2'd0, 1'b0, 1'b0, 26'h0000016, 25'h0000006, 1'b1, 1'b1, 1'b1},
        {2'd0, 1'b0, 1'b1, 26'h0000012, 25'h0000005, 1'b1, 1'b1, 1'b1},
        {2'd0, 1'b0, 1'b0, 26'h0000013, 25'h0000005, 1'b1, 1'b1, 1'b1},
        {2'd0, 1'b0, 1'b1, 26'h0000011, 25'h0000004, 1'b0, 1'b1, 1'b1},
        {2'd1, 1'b0, 1'b1, 26'h0000017, 25'h0000005, 1'b0, 1'b1, 1'b0},
        {2'd1, 1'b1, 1'b1, 26'h0000017, 25'h0000005, 1'b0, 1'b1, 1'b0},
        {2'd2, 1'b0, 1'b0, 26'h0000011, 25'h0000005, 1'b1, 1'b1, 1'b1},
        {2'd2, 1'b1, 1'b0, 26'h0000011, 25'h0000004, 1'b0, 1'b1, 1'b0},
        {2'd3, 1'b1, 1'b1, 26'h0000010, 25'h0000005, 1'b1, 1'b1, 1'b1},
        {2'd3, 1'b0, 1'b1, 26'h0000010, 25'h0000004, 1'b0, 1'b1, 1'b0},
        {2'd0, 1'b0, 1'b0, 26'h3FFFFFF, 25'h1000000, 1'b1, 1'b1, 1'b1},
        {2'd2, 1'b0, 1'b0, 26'h3FFFFFC, 25'h0FFFFFF, 1'b0, 1'b0, 1'b1},
        {2'd3, 1'b0, 1'b0, 26'h0000000, 25'h0000000, 1'b0, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b0, 26'h0000002, 25'h0000000, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] md, input logic sg, input logic st,
                         input logic [MW-1:0] m);
        @(negedge clk);
        mode = md; sign = sg; sticky = st; mant = m;
        @(posedge clk);
        #1;
    endtask

    function automatic string mode_req(input logic [1:0] md);
        case (md)
            2'd1:    return "R5";
            2'd2:    return "R6";
            2'd3:    return "R7";
            default: return "R4";
        endcase
    endfunction

    initial begin
        mant = '0; sticky = 0; sign = 0; mode = 2'd0;
        @(posedge clk); #1;
        check("R2 idle flags", {30'd0, inx_o, up_o}, 32'd0);

        for (int i = 0; i < 16; i++) begin
            logic [57:0] v;
            v = VECS[i];
            apply(v[57:56], v[55], v[54], v[53:28]);
            check(mode_req(v[57:56]), 32'(mant_o), 32'(v[27:3]));
            check("R8 rounded-up pair", {30'd0, up_o, fr_o}, {30'd0, v[2], v[2]});
            check(v[1] ? "R3" : "R2", {30'd0, inx_o, fi_o}, {30'd0, v[1], v[1]});
            check("R9", 32'(inf_o), 32'(v[0]));
            check("R10", 32'(ovf_o), 32'(v[0]));
        end

        // R1: toward zero over varied patterns returns plain shift
        for (int k = 0; k < 20; k++) begin
            logic [MW-1:0] m;
            m = MW'(32'h9E3779B9 * (k + 1));
            apply(2'd1, k[0], k[1], m);
            check("R1 shift", 32'(mant_o), 32'({1'b0, m[MW-1:2]}));
        end

        // R8 carry out of the all-ones field under toward plus infinity
        apply(2'd2, 1'b0, 1'b1, 26'h3FFFFFC);
        check("R8 carry", 32'(mant_o), 32'h1000000);

        // R4 halfway with odd retained value rounds to even
        apply(2'd0, 1'b1, 1'b0, 26'h000000E);
        check("R4 tie odd", 32'(mant_o), 32'h4);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule